// File: doc/BRIEF.md
# FEC Error Injection and Block Statistics

This block is the management-side companion of a forward error correction path. On the transmit side it holds a small error-injection configuration. A one-shot insert command turns that configuration into a single error request toward the encoder datapath. The request is either a one-cycle transcoder error strobe, a burst-error enable held for a programmed number of cycles, or both.

On the receive side the block counts per-block event pulses from the decoder in two saturating counters. One counter is for blocks that were corrected and one is for blocks that could not be corrected. Reading a counter returns its value and clears it in the same cycle. An event that arrives in the cycle of the read is not lost.

Software reaches the block through a simple single-cycle register bus. Read data comes back one cycle after the read strobe.

Top module: `fec_inj_stats`

## Requirements
- R1: After reset, both error outputs are low, the read-valid output is low, and every register reads as 0.
- R2: Register address 0 holds the configuration: bit 0 enables transcoder errors, bit 1 enables burst errors, and bits 5:2 hold the burst length code. A read returns these stored bits, and bit 8 (the insert command) always reads as 0.
- R3: A write to address 0 with bit 8 and bit 0 set drives `errTrans` high for exactly the one cycle after the write edge.
- R4: A write to address 0 with bit 8 and bit 1 set drives `errBurst` high for N+1 consecutive cycles, starting the cycle after the write edge. N is the length code written in bits 5:2, so bursts of 1 to 16 cycles are possible.
- R5: An insert command written with both bit 0 and bit 1 clear produces no pulse on either error output.
- R6: An insert command written while a burst is still in progress is ignored as a whole. The running burst is not restarted and no transcoder strobe is issued.
- R7: Each `corrEvt` or `uncEvt` pulse adds one to its counter. A read of address 1 (corrected) or address 2 (uncorrectable) returns the count on `regRdData`, with `regRdValid` high, one cycle after the read strobe.
- R8: A counter read returns the value held before the read edge and leaves the counter at 0. If an event for that counter arrives in the same cycle, the counter restarts at 1 instead.
- R9: A counter that reaches its all-ones maximum (2^CNT_W-1) stays there on further events until it is read.
- R10: Reads of address 3 return 0. Writes to addresses 1 and 2 leave the counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data, valid with regRdValid |
| regRdValid | output | 1 | High the cycle after a read strobe |
| corrEvt | input | 1 | One pulse per corrected block |
| uncEvt | input | 1 | One pulse per uncorrectable block |
| errTrans | output | 1 | Transcoder error request, one cycle |
| errBurst | output | 1 | Encoder burst error enable, held N+1 cycles |

## Verification
On every cycle the assertions check four things: an error output only starts right after a matching insert write; a counter at its maximum holds unless it is read; a read leaves the counter at 0 or 1; and read data is always valid one cycle after the strobe, with the insert bit reading as 0. Some behaviours only the bench scenarios can show. These are the exact burst length for each code, the dropping of a command during a busy burst, and the same-cycle read-and-event case. They also include saturation, which the bench reaches through a narrow-counter instance, and count agreement with a model under random events and reads.

// File: rtl/fec_inj_pkg.sv
package fec_inj_pkg;
  localparam int LEN_W      = 4;
  localparam int NUM_CNT    = 2;
  localparam int ADDR_CFG   = 0;
  localparam int ADDR_CORR  = 1;
  localparam int ADDR_UNC   = 2;
  localparam int BIT_TRANS  = 0;
  localparam int BIT_BURST  = 1;
  localparam int LEN_LSB    = 2;
  localparam int BIT_INSERT = 8;

  // control -> datapath strobes and configuration view
  typedef struct packed {
    logic               insertGo;
    logic               goTrans;
    logic               goBurst;
    logic [LEN_W-1:0]   goLen;
    logic               rdAny;
    logic               rdCfg;
    logic [NUM_CNT-1:0] rdCnt;
    logic               cfgTrans;
    logic               cfgBurst;
    logic [LEN_W-1:0]   cfgLen;
  } ctrlStrobe_t;
endpackage

// File: rtl/fec_inj_ctrl.sv
module fec_inj_ctrl
  import fec_inj_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              burstBusy,
  output ctrlStrobe_t       strobe
);
  logic             cfgTransQ;
  logic             cfgBurstQ;
  logic [LEN_W-1:0] cfgLenQ;
  logic             hitCfg;
  logic             hitCorr;
  logic             hitUnc;
  logic             unusedBits;

  assign hitCfg  = (regAddr == ADDR_W'(ADDR_CFG));
  assign hitCorr = (regAddr == ADDR_W'(ADDR_CORR));
  assign hitUnc  = (regAddr == ADDR_W'(ADDR_UNC));
  assign unusedBits = ^{regWrData[DATA_W-1:BIT_INSERT+1],
                        regWrData[BIT_INSERT-1:LEN_LSB+LEN_W]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgTransQ <= 1'b0;
      cfgBurstQ <= 1'b0;
      cfgLenQ   <= '0;
    end else if (regWrEn && hitCfg) begin
      cfgTransQ <= regWrData[BIT_TRANS];
      cfgBurstQ <= regWrData[BIT_BURST];
      cfgLenQ   <= regWrData[LEN_LSB +: LEN_W];
    end
  end

  always_comb begin
    strobe.insertGo = regWrEn && hitCfg && regWrData[BIT_INSERT] && !burstBusy &&
                      (regWrData[BIT_TRANS] || regWrData[BIT_BURST]);
    strobe.goTrans  = regWrData[BIT_TRANS];
    strobe.goBurst  = regWrData[BIT_BURST];
    strobe.goLen    = regWrData[LEN_LSB +: LEN_W];
    strobe.rdAny    = regRdEn;
    strobe.rdCfg    = regRdEn && hitCfg;
    strobe.rdCnt    = {regRdEn && hitUnc, regRdEn && hitCorr};
    strobe.cfgTrans = cfgTransQ;
    strobe.cfgBurst = cfgBurstQ;
    strobe.cfgLen   = cfgLenQ;
  end
endmodule

// File: rtl/fec_inj_dp.sv
module fec_inj_dp
  import fec_inj_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              corrEvt,
  input  logic              uncEvt,
  output logic              burstBusy,
  output logic              errTrans,
  output logic              errBurst,
  output logic [DATA_W-1:0] regRdData,
  output logic              regRdValid,
  output logic [CNT_W-1:0]  corrCnt,
  output logic [CNT_W-1:0]  uncCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_CNT-1:0] evtVec;
  logic [CNT_W-1:0]   cntQ [NUM_CNT];
  logic               transQ;
  logic               burstOnQ;
  logic [LEN_W-1:0]   burstLeftQ;
  logic [DATA_W-1:0]  cfgWord;

  assign evtVec = {uncEvt, corrEvt};

  // saturating statistics counters, cleared by a read
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ[i] <= '0;
      end else if (strobe.rdCnt[i]) begin
        cntQ[i] <= evtVec[i] ? CNT_W'(1) : '0;
      end else if (evtVec[i] && (cntQ[i] != CNT_MAX)) begin
        cntQ[i] <= cntQ[i] + CNT_W'(1);
      end
    end
  end

  // error pulse shaper
  always_ff @(posedge clk) begin
    if (!rstN) begin
      transQ     <= 1'b0;
      burstOnQ   <= 1'b0;
      burstLeftQ <= '0;
    end else begin
      transQ <= strobe.insertGo && strobe.goTrans;
      if (strobe.insertGo && strobe.goBurst) begin
        burstOnQ   <= 1'b1;
        burstLeftQ <= strobe.goLen;
      end else if (burstOnQ) begin
        if (burstLeftQ == '0) burstOnQ <= 1'b0;
        else                  burstLeftQ <= burstLeftQ - LEN_W'(1);
      end
    end
  end

  always_comb begin
    cfgWord = '0;
    cfgWord[BIT_TRANS]          = strobe.cfgTrans;
    cfgWord[BIT_BURST]          = strobe.cfgBurst;
    cfgWord[LEN_LSB +: LEN_W]   = strobe.cfgLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdValid <= 1'b0;
      regRdData  <= '0;
    end else begin
      regRdValid <= strobe.rdAny;
      if (strobe.rdAny) begin
        if (strobe.rdCfg)         regRdData <= cfgWord;
        else if (strobe.rdCnt[0]) regRdData <= DATA_W'(cntQ[0]);
        else if (strobe.rdCnt[1]) regRdData <= DATA_W'(cntQ[1]);
        else                      regRdData <= '0;
      end
    end
  end

  assign burstBusy = burstOnQ;
  assign errTrans  = transQ;
  assign errBurst  = burstOnQ;
  assign corrCnt   = cntQ[0];
  assign uncCnt    = cntQ[1];
endmodule

// File: rtl/fec_inj_stats.sv
module fec_inj_stats
  import fec_inj_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              regRdValid,
  input  logic              corrEvt,
  input  logic              uncEvt,
  output logic              errTrans,
  output logic              errBurst
);
  ctrlStrobe_t      strobe;
  logic             burstBusy;
  logic [CNT_W-1:0] corrCnt;
  logic [CNT_W-1:0] uncCnt;

  fec_inj_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .burstBusy(burstBusy),
    .strobe(strobe)
  );

  fec_inj_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .corrEvt(corrEvt),
    .uncEvt(uncEvt), .burstBusy(burstBusy), .errTrans(errTrans),
    .errBurst(errBurst), .regRdData(regRdData), .regRdValid(regRdValid),
    .corrCnt(corrCnt), .uncCnt(uncCnt)
  );
endmodule

// File: rtl/fec_inj_stats_chk.sv
module fec_inj_stats_chk
  import fec_inj_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wrInsBit,
  input logic              wrTransBit,
  input logic              wrBurstBit,
  input logic              rdInsBit,
  input logic              regRdValid,
  input logic              errTrans,
  input logic              errBurst,
  input logic [CNT_W-1:0]  corrCnt,
  input logic [CNT_W-1:0]  uncCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic cfgHit;
  logic corrRd;
  logic uncRd;
  assign cfgHit = regAddr == ADDR_W'(ADDR_CFG);
  assign corrRd = regRdEn && (regAddr == ADDR_W'(ADDR_CORR));
  assign uncRd  = regRdEn && (regAddr == ADDR_W'(ADDR_UNC));

  p_trans_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    errTrans |-> $past(regWrEn && cfgHit && wrInsBit && wrTransBit));

  p_burst_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errBurst) |-> $past(regWrEn && cfgHit && wrInsBit && wrBurstBit));

  p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (corrCnt == CNT_MAX && !corrRd) |=> corrCnt == CNT_MAX);

  p_sat_hold_unc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (uncCnt == CNT_MAX && !uncRd) |=> uncCnt == CNT_MAX);

  p_clear_corr_r8: assert property (@(posedge clk) disable iff (!rstN)
    corrRd |=> corrCnt <= CNT_W'(1));

  p_clear_unc_r8: assert property (@(posedge clk) disable iff (!rstN)
    uncRd |=> uncCnt <= CNT_W'(1));

  p_rd_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regRdValid);

  p_ins_reads_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && cfgHit) |=> !rdInsBit);
endmodule

bind fec_inj_stats fec_inj_stats_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
  .wrInsBit(regWrData[8]), .wrTransBit(regWrData[0]), .wrBurstBit(regWrData[1]),
  .rdInsBit(regRdData[8]), .regRdValid(regRdValid), .errTrans(errTrans),
  .errBurst(errBurst), .corrCnt(corrCnt), .uncCnt(uncCnt)
);

// File: tb/fec_inj_stats_tb.sv
module fec_inj_stats_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic        evtC = 1'b0;
  logic        evtU = 1'b0;
  logic [31:0] rdDataA, rdDataB;
  logic        rdValidA, rdValidB, transA, transB, burstA, burstB;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  fec_inj_stats u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(wrEn), .regRdEn(rdEn), .regAddr(addr),
    .regWrData(wrData), .regRdData(rdDataA), .regRdValid(rdValidA),
    .corrEvt(evtC), .uncEvt(evtU), .errTrans(transA), .errBurst(burstA)
  );

  fec_inj_stats #(.CNT_W(4)) u_dutSmall (
    .clk(clk), .rstN(rstN), .regWrEn(wrEn), .regRdEn(rdEn), .regAddr(addr),
    .regWrData(wrData), .regRdData(rdDataB), .regRdValid(rdValidB),
    .corrEvt(evtC), .uncEvt(evtU), .errTrans(transB), .errBurst(burstB)
  );

  function automatic logic [31:0] satInc(input logic [31:0] v, input logic [31:0] mx);
    return (v == mx) ? v : v + 32'd1;
  endfunction

  function automatic logic [31:0] cfgWord(input logic ins, input logic tr,
                                          input logic bu, input logic [3:0] len);
    return {23'd0, ins, 2'd0, len, bu, tr};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all operations start and end just after a falling edge
  task automatic doWrite(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doRead(input logic [1:0] a, output logic [31:0] dA, output logic [31:0] dB);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    chk("R7 valid", {31'd0, rdValidA}, 32'd1);
    dA = rdDataA; dB = rdDataB;
  endtask

  task automatic countBurst(output int n);
    n = 0;
    while (burstA === 1'b1 && n < 40) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    logic [31:0] mA [2];
    logic [31:0] mB [2];
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 trans", {31'd0, transA}, 0);
    chk("R1 burst", {31'd0, burstA}, 0);
    chk("R1 valid", {31'd0, rdValidA}, 0);
    doRead(2'd0, a, b); chk("R1 cfg", a, 0);
    doRead(2'd1, a, b); chk("R1 corr", a, 0);
    doRead(2'd2, a, b); chk("R1 unc", a, 0);

    // R2 config readback without insert
    doWrite(2'd0, cfgWord(1'b0, 1'b1, 1'b0, 4'd9));
    chk("R2 no pulse", {30'd0, transA, burstA}, 0);
    doRead(2'd0, a, b); chk("R2 readback", a, cfgWord(1'b0, 1'b1, 1'b0, 4'd9));

    // R3 transcoder pulse
    doWrite(2'd0, cfgWord(1'b1, 1'b1, 1'b0, 4'd3));
    chk("R3 trans high", {31'd0, transA}, 1);
    chk("R3 burst low", {31'd0, burstA}, 0);
    @(negedge clk);
    chk("R3 trans single", {31'd0, transA}, 0);
    doRead(2'd0, a, b); chk("R2 insert reads 0", a, cfgWord(1'b0, 1'b1, 1'b0, 4'd3));

    // R4 burst lengths: corners then random
    for (int k = 0; k < 6; k++) begin
      logic [3:0] code;
      code = (k == 0) ? 4'd0 : (k == 1) ? 4'd15 : 4'($urandom % 16);
      doWrite(2'd0, cfgWord(1'b1, 1'b0, 1'b1, code));
      countBurst(n);
      chk("R4 burst length", n, 32'(code) + 1);
    end

    // both modes at once
    doWrite(2'd0, cfgWord(1'b1, 1'b1, 1'b1, 4'd5));
    chk("R3 trans with burst", {31'd0, transA}, 1);
    countBurst(n);
    chk("R4 burst with trans", n, 6);

    // R5 suppression
    doWrite(2'd0, cfgWord(1'b1, 1'b0, 1'b0, 4'd7));
    chk("R5 suppressed", {30'd0, transA, burstA}, 0);
    @(negedge clk);
    chk("R5 still quiet", {30'd0, transA, burstA}, 0);

    // R6 command during busy burst is dropped
    doWrite(2'd0, cfgWord(1'b1, 1'b0, 1'b1, 4'd10));
    n = 1;
    @(negedge clk); n += burstA;
    doWrite(2'd0, cfgWord(1'b1, 1'b1, 1'b1, 4'd0));
    chk("R6 no trans while busy", {31'd0, transA}, 0);
    n += burstA;
    @(negedge clk);
    while (burstA === 1'b1 && n < 40) begin n++; @(negedge clk); end
    chk("R6 burst not restarted", n, 11);

    // counters: clear, then count and saturate
    doRead(2'd1, a, b); doRead(2'd2, a, b);
    evtC = 1'b1; repeat (20) @(negedge clk); evtC = 1'b0;
    evtU = 1'b1; repeat (3) @(negedge clk); evtU = 1'b0;
    doRead(2'd1, a, b);
    chk("R7 corr count", a, 20);
    chk("R9 saturate small", b, 15);
    doRead(2'd1, a, b);
    chk("R8 cleared", a, 0);
    chk("R8 small cleared", b, 0);
    doRead(2'd2, a, b);
    chk("R7 unc count", a, 3);

    // R8 event in read cycle
    evtU = 1'b1; repeat (2) @(negedge clk);
    doRead(2'd2, a, b);
    evtU = 1'b0;
    chk("R8 old value", a, 2);
    doRead(2'd2, a, b);
    chk("R8 restart at 1", a, 1);

    // R10 unused address and counter writes
    evtC = 1'b1; repeat (2) @(negedge clk); evtC = 1'b0;
    doWrite(2'd1, 32'hFFFF);
    doWrite(2'd2, 32'hFFFF);
    doRead(2'd3, a, b); chk("R10 addr3 zero", a, 0);
    doRead(2'd1, a, b); chk("R10 write ignored", a, 2);
    doRead(2'd2, a, b); chk("R10 write ignored unc", a, 0);

    // random events and reads against a model
    mA[0] = 0; mA[1] = 0; mB[0] = 0; mB[1] = 0;
    for (int it = 0; it < 600; it++) begin
      logic [1:0] ev;
      int op;
      logic [31:0] eA, eB;
      ev = 2'($urandom % 4);
      op = $urandom % 6;
      evtC = ev[0]; evtU = ev[1];
      rdEn = (op < 2); addr = (op == 0) ? 2'd1 : 2'd2;
      eA = (op < 2) ? mA[op] : 0;
      eB = (op < 2) ? mB[op] : 0;
      for (int i = 0; i < 2; i++) begin
        if (op == i) begin
          mA[i] = ev[i] ? 1 : 0; mB[i] = ev[i] ? 1 : 0;
        end else if (ev[i]) begin
          mA[i] = satInc(mA[i], 32'hFFFF_FFFF); mB[i] = satInc(mB[i], 32'd15);
        end
      end
      @(negedge clk);
      if (op < 2) begin
        chk("R7 random read", rdDataA, eA);
        chk("R9 random read small", rdDataB, eB);
      end
    end
    rdEn = 1'b0; evtC = 1'b0; evtU = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule